// File: doc/BRIEF.md
# SDRAM Auto-Refresh Request Scheduler

This block decides when an SDRAM controller should run an auto-refresh. A down-counter is loaded from a programmable interval. Each time it runs out, it raises a refresh request toward the command sequencer. The request is held until the sequencer reports completion with refresh-done. While a refresh is wanted or running, the block withholds grants from the memory-access side. A refresh that falls due during an access in progress waits for that access to end.

Software programs the block through one 32-bit control word. The word holds a run/stop bit, a 4-bit refresh-count field that is passed straight through to the sequencer, and a 12-bit interval. Stopping is deferred. After a 0 is written to the run bit, one further refresh is still issued and completed. Only then does the bit read back as 0, so firmware can poll it to learn that refreshing has actually stopped.

Top module: `refresh_sched`

## Requirements
- R1: The control word has these fields: bit 16 is the run bit, bits 15:12 are the refresh-count field, and bits 11:0 are the interval N. Each field reads back as it was last written, except where R6 says otherwise.
- R2: Bits 31:17 always read 0. Values written to them have no effect.
- R3: After reset the control word reads 0. No refresh request is raised while the run bit is 0.
- R4: A write of the run bit as 1 with interval N raises `ref_req` at the (N+1)th clock edge after the write edge. Any register write restarts the interval. When each refresh is acknowledged in its first cycle and no access is busy, further requests rise every N+1 edges.
- R5: Interval 0 makes the counter expire every cycle without locking up. With immediate acknowledgement, `ref_req` rises on every second edge.
- R6: Writing the run bit as 0 while it is 1 lets the next refresh still be issued. The run bit keeps reading 1 until the edge on which that refresh is acknowledged, and reads 0 from then on. No further requests follow.
- R7: `ref_req` never rises on the edge that ends a cycle in which `acc_busy` was high. A refresh that comes due during a busy access waits until the first cycle with `acc_busy` low.
- R8: In a cycle in which a refresh is due and `acc_req` is high with `acc_busy` low, the refresh is chosen and `acc_gnt` stays low.
- R9: At most one refresh is held pending. Expiries that occur while a refresh is already pending are dropped.
- R10: `ref_req` stays high until the edge that samples `ref_done` high. `acc_gnt` is low for that whole window. Outside it, with no refresh due and no busy access, `acc_req` is granted in the same cycle.
- R11: `ref_count` always equals the stored refresh-count field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| acc_req | input | 1 | Memory-access side asks for a grant |
| acc_busy | input | 1 | An SDRAM access is in progress |
| acc_gnt | output | 1 | Access granted this cycle (combinational) |
| ref_req | output | 1 | Refresh request to the command sequencer |
| ref_done | input | 1 | Sequencer has completed the refresh |
| ref_count | output | 4 | Refresh-count field passed to the sequencer |

## Verification
The grant is combinational, so it is checked in the same cycle in which the request and busy inputs are driven. A refresh decision made in cycle c shows on `ref_req` after edge c+1. From a write edge with interval N, the first request therefore rises N+1 edges later. The run bit clears on the edge that samples `ref_done`. The bench drives all inputs at the falling edge and samples there as well. Its driver queues the exact edge number at which each `ref_req` rise is due, and a monitor pops one entry per rise it sees. Any rise that comes early, comes late, is missing or is extra is therefore reported.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    localparam int REG_W_DEF  = 32;
    localparam int IVAL_W_DEF = 12;
    localparam int RCNT_W_DEF = 4;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_REF  = 2'd1,
        PICK_ACC  = 2'd2
    } pick_e;
endpackage

// File: rtl/rfs_cfg_reg.sv
module rfs_cfg_reg #(
    parameter int REG_W  = rfs_pkg::REG_W_DEF,
    parameter int IVAL_W = rfs_pkg::IVAL_W_DEF,
    parameter int RCNT_W = rfs_pkg::RCNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              ref_fin_i,
    output logic              run_o,
    output logic [RCNT_W-1:0] rcnt_o,
    output logic [IVAL_W-1:0] ival_next_o,
    output logic [REG_W-1:0]  rd_data_o
);
    localparam int RUN_POS = IVAL_W + RCNT_W;

    typedef struct packed {
        logic              run;
        logic              stopping;
        logic [RCNT_W-1:0] rcnt;
        logic [IVAL_W-1:0] ival;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_q.stopping && ref_fin_i) begin
            cfg_d.run      = 1'b0;
            cfg_d.stopping = 1'b0;
        end
        if (wr_en_i) begin
            cfg_d.rcnt = wr_data_i[RUN_POS-1:IVAL_W];
            cfg_d.ival = wr_data_i[IVAL_W-1:0];
            if (wr_data_i[RUN_POS]) begin
                cfg_d.run      = 1'b1;
                cfg_d.stopping = 1'b0;
            end else if (cfg_d.run) begin
                cfg_d.stopping = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data_o              = '0;
        rd_data_o[RUN_POS:0]   = {cfg_q.run, cfg_q.rcnt, cfg_q.ival};
    end

    assign run_o       = cfg_q.run;
    assign rcnt_o      = cfg_q.rcnt;
    assign ival_next_o = cfg_d.ival;

    // R6: the run bit only drops on an acknowledged refresh
    p_deferred_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_q.run) |-> $past(ref_fin_i));
endmodule

// File: rtl/rfs_ival_timer.sv
module rfs_ival_timer #(
    parameter int IVAL_W = rfs_pkg::IVAL_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              load_i,
    input  logic [IVAL_W-1:0] load_val_i,
    output logic              tick_o
);
    logic [IVAL_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i || load_i || cnt_q == '0) cnt_d = load_val_i;
        else                                 cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/rfs_arbiter.sv
module rfs_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    input  logic acc_req_i,
    input  logic acc_busy_i,
    input  logic ref_done_i,
    output logic ref_req_o,
    output logic ref_fin_o,
    output logic acc_gnt_o
);
    import rfs_pkg::*;

    typedef struct packed {
        logic pend;
        logic req;
    } arb_t;

    arb_t  arb_d, arb_q;
    pick_e pick;
    logic  want;

    always_comb begin
        want = run_i && (arb_q.pend || tick_i);
        pick = PICK_NONE;
        if (!arb_q.req && !acc_busy_i) begin
            if (want)           pick = PICK_REF;
            else if (acc_req_i) pick = PICK_ACC;
        end
        arb_d      = arb_q;
        if (arb_q.req && ref_done_i) arb_d.req = 1'b0;
        if (pick == PICK_REF)        arb_d.req = 1'b1;
        arb_d.pend = want && (pick != PICK_REF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    assign ref_req_o = arb_q.req;
    assign ref_fin_o = arb_q.req && ref_done_i;
    assign acc_gnt_o = (pick == PICK_ACC);

    // R3: a request only starts while running
    p_no_req_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_q.req) |-> $past(run_i));
    // R7: a request never starts out of a busy cycle
    p_wait_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_q.req) |-> !$past(acc_busy_i));
    // R10: request held until acknowledged
    p_hold_until_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_q.req && !ref_done_i) |=> arb_q.req);
    // R8: a granted access is never in the same cycle as a refresh launch
    p_tie_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt_o |=> !$rose(arb_q.req));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int REG_W  = rfs_pkg::REG_W_DEF,
    parameter int IVAL_W = rfs_pkg::IVAL_W_DEF,
    parameter int RCNT_W = rfs_pkg::RCNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              acc_req,
    input  logic              acc_busy,
    output logic              acc_gnt,
    output logic              ref_req,
    input  logic              ref_done,
    output logic [RCNT_W-1:0] ref_count
);
    logic              run;
    logic              tick;
    logic              ref_fin;
    logic [IVAL_W-1:0] ival_next;

    rfs_cfg_reg #(.REG_W(REG_W), .IVAL_W(IVAL_W), .RCNT_W(RCNT_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (reg_we),
        .wr_data_i   (reg_wdata),
        .ref_fin_i   (ref_fin),
        .run_o       (run),
        .rcnt_o      (ref_count),
        .ival_next_o (ival_next),
        .rd_data_o   (reg_rdata)
    );

    rfs_ival_timer #(.IVAL_W(IVAL_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .load_i     (reg_we),
        .load_val_i (ival_next),
        .tick_o     (tick)
    );

    rfs_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .tick_i     (tick),
        .acc_req_i  (acc_req),
        .acc_busy_i (acc_busy),
        .ref_done_i (ref_done),
        .ref_req_o  (ref_req),
        .ref_fin_o  (ref_fin),
        .acc_gnt_o  (acc_gnt)
    );
endmodule

// File: tb/sim_refresh_sched.sv
`timescale 1ns/1ps
module sim_refresh_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_req = 1'b0;
    logic        acc_busy = 1'b0;
    logic        acc_gnt;
    logic        ref_req;
    logic        ref_done;
    logic [3:0]  ref_count;
    logic        auto_done = 1'b0;
    logic        man_done = 1'b0;
    logic        prev_ref = 1'b0;
    logic        prev_busy = 1'b0;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          exp_q[$];
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) begin
        cyc       <= cyc + 1;
        prev_ref  <= ref_req;
        prev_busy <= acc_busy;
    end

    assign ref_done = auto_done ? ref_req : man_done;

    refresh_sched u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .acc_req(acc_req), .acc_busy(acc_busy),
        .acc_gnt(acc_gnt), .ref_req(ref_req), .ref_done(ref_done),
        .ref_count(ref_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: each ref_req rise must match the next queued edge number
    always @(negedge clk) begin
        if (rst_n && ref_req && !prev_ref) begin
            if (exp_q.size() == 0) begin
                check("R3/R9 unexpected refresh request at edge", cyc, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                check("R4 refresh request edge", cyc, e);
            end
            check("R7 request rose out of busy cycle", {31'b0, prev_busy}, 0);
        end
    end

    task automatic wr(input logic [31:0] v, output int edge_n);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        edge_n = cyc;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int k;
        int j;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R3 reset read data", reg_rdata, 32'h0);
        check("R3 reset ref_req", {31'b0, ref_req}, 0);
        acc_req = 1'b1;
        #1 check("R10 idle access grant", {31'b0, acc_gnt}, 1);
        acc_req = 1'b0;

        // field layout, reserved bits, run bit off
        wr(32'hFFFE_5ABC, k);
        check("R2 reserved bits read zero", reg_rdata, 32'h0000_5ABC);
        check("R1 interval field", {20'b0, reg_rdata[11:0]}, 32'hABC);
        check("R11 refresh count output", {28'b0, ref_count}, 5);
        wait_to(k + 20);
        check("R3 no request while stopped", {31'b0, ref_req}, 0);

        // periodic requests, N = 4
        auto_done = 1'b1;
        wr(32'h0001_0004, k);
        check("R1 run bit reads back", {31'b0, reg_rdata[16]}, 1);
        check("R11 count field zero", {28'b0, ref_count}, 0);
        exp_q.push_back(k + 5);
        exp_q.push_back(k + 10);
        exp_q.push_back(k + 15);
        wait_to(k + 16);
        check("R4 all periodic requests seen", exp_q.size(), 0);
        wr(32'h0000_0004, j);
        exp_q.push_back(j + 5);
        check("R6 run bit still set after stop write", {31'b0, reg_rdata[16]}, 1);
        wait_to(j + 5);
        check("R6 run bit set during final refresh", {31'b0, reg_rdata[16]}, 1);
        wait_to(j + 6);
        check("R6 run bit clear after final refresh", {31'b0, reg_rdata[16]}, 0);
        wait_to(j + 26);
        check("R6 no requests after stop", exp_q.size(), 0);

        // interval 0
        wr(32'h0001_0000, k);
        exp_q.push_back(k + 1);
        exp_q.push_back(k + 3);
        exp_q.push_back(k + 5);
        exp_q.push_back(k + 7);
        exp_q.push_back(k + 9);
        wait_to(k + 7);
        wr(32'h0000_0000, j);
        wait_to(k + 10);
        check("R5 stop after interval-0 run", {31'b0, reg_rdata[16]}, 0);
        wait_to(k + 25);
        check("R5 interval-0 request train", exp_q.size(), 0);

        // busy deferral and single pending, N = 3
        acc_busy = 1'b1;
        wr(32'h0001_0003, k);
        exp_q.push_back(k + 13);
        exp_q.push_back(k + 16);
        wait_to(k + 10);
        check("R7 held off while busy", {31'b0, ref_req}, 0);
        wait_to(k + 12);
        acc_busy = 1'b0;
        wait_to(k + 17);
        check("R9 one pending refresh only", exp_q.size(), 0);
        wr(32'h0000_0003, j);
        exp_q.push_back(k + 22);
        wait_to(k + 23);
        check("R6 stop after deferred run", {31'b0, reg_rdata[16]}, 0);
        wait_to(k + 35);
        check("R9 no extra requests", exp_q.size(), 0);

        // tie and hold, N = 5
        auto_done = 1'b0;
        wr(32'h0001_0005, k);
        exp_q.push_back(k + 6);
        wait_to(k + 4);
        acc_req = 1'b1;
        #1 check("R10 grant when no refresh due", {31'b0, acc_gnt}, 1);
        wait_to(k + 5);
        #1 check("R8 refresh wins tie", {31'b0, acc_gnt}, 0);
        wait_to(k + 6);
        check("R10 request raised", {31'b0, ref_req}, 1);
        check("R10 no grant during refresh", {31'b0, acc_gnt}, 0);
        wait_to(k + 9);
        check("R10 request held without done", {31'b0, ref_req}, 1);
        check("R10 no grant while held", {31'b0, acc_gnt}, 0);
        man_done = 1'b1;
        wait_to(k + 10);
        man_done = 1'b0;
        #1;
        check("R10 request released by done", {31'b0, ref_req}, 0);
        check("R10 grant resumes after done", {31'b0, acc_gnt}, 1);
        acc_req = 1'b0;
        auto_done = 1'b1;
        exp_q.push_back(k + 12);
        wait_to(k + 13);
        wr(32'h0000_0005, j);
        exp_q.push_back(k + 20);
        wait_to(k + 21);
        check("R6 stop after tie test", {31'b0, reg_rdata[16]}, 0);
        wait_to(k + 35);
        check("R4 final queue empty", exp_q.size(), 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule